// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control path a small processor core uses to enter and leave interrupt handlers. It watches a set of request lines with fixed priority, an instruction-boundary strobe and decoded return, enable, disable and sleep instructions. It owns the stack pointer, the global-enable bit and the low-power (CPU-off) bit. It issues one stack transfer per cycle, and it tells the fetch unit whether the next fetch goes to a vector table entry or to a program address.

Entry pushes the return address and then the status word, clears enable and low-power, and then hands the fetch unit the vector of the winning request. Return pops the status word first, so the restored enable and low-power bits apply at once, and then pops the return address. If a request is pending and enable has come back on, the sequencer does not redirect to the program. It pushes the address it has just popped and enters the next handler, so no program instruction runs between the two handlers. An enable instruction always lets one more instruction complete before any request is taken.

Top module: `irq_sequencer`

## Requirements
- R1: While the core is awake, a request is accepted only in a cycle where `insn_done` is high for an instruction that is not return, enable, disable or sleep. While `insn_done` is low, pending requests start no stack transfer.
- R2: Acceptance takes three cycles. Cycle 1 writes `next_pc` to address `sp-2`. Cycle 2 writes the status word to `sp-4`: `sr_in` with bit 3 replaced by global enable and bit 4 replaced by CPU-off. Cycle 3 pulses `redirect` with `redirect_vec` high, and both enable bits read 0 in that cycle.
- R3: Request line 0 has the highest priority. The vector address is `VEC_BASE + 2*index` of the winning line, and `irq_ack` is one-hot on that line in the vector cycle.
- R4: A return instruction reads the status word at `sp` with `sr_load` high, then reads the return address at `sp+2`. When no chaining occurs, it pulses `redirect` with `redirect_vec` low and `redirect_addr` equal to the popped address.
- R5: Bit 3 and bit 4 of the popped status word become `gie` and `cpuoff` in the cycle after the status pop. A restored CPU-off of 1 puts the core back to sleep.
- R6: If enable is restored and a request is pending when the return address is popped, there is no program redirect. The next cycle pushes the popped address, and entry to the new handler follows.
- R7: At the boundary of an enable instruction, no request is accepted even if one is pending. The following instruction completes, and acceptance happens at its boundary.
- R8: With enable cleared, either from reset or from a disable instruction (whose own boundary is masked), no request is accepted.
- R9: A sleep instruction sets CPU-off. A request that arrives while asleep with enable set starts acceptance without any boundary strobe, and the pushed status word has bit 4 set.
- R10: The stack pointer drops by 2 after each push cycle and rises by 2 after each pop cycle.
- R11: After reset, `sp` equals `SP_INIT`, `gie`, `cpuoff` and `busy` are 0, and no stack transfer is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NREQ | Pending request lines, line 0 highest priority |
| insn_done | input | 1 | The current instruction completes this cycle |
| op_reti | input | 1 | Completing instruction is return-from-interrupt |
| op_eint | input | 1 | Completing instruction enables interrupts |
| op_dint | input | 1 | Completing instruction disables interrupts |
| op_sleep | input | 1 | Completing instruction enters low-power mode |
| next_pc | input | AW | Address of the next program instruction |
| sr_in | input | AW | Status word from the datapath |
| stk_rdata | input | AW | Stack read data (combinational read) |
| stk_we | output | 1 | Stack write this cycle |
| stk_re | output | 1 | Stack read this cycle |
| stk_addr | output | AW | Stack transfer address |
| stk_wdata | output | AW | Stack write data |
| sr_load | output | 1 | Datapath loads its status word from `stk_rdata` |
| sp | output | AW | Stack pointer |
| gie | output | 1 | Global interrupt enable |
| cpuoff | output | 1 | Low-power state, fetch halted |
| busy | output | 1 | Entry or return sequence in progress |
| redirect | output | 1 | Next fetch goes to `redirect_addr` |
| redirect_vec | output | 1 | `redirect_addr` is a vector table entry |
| redirect_addr | output | AW | Redirect target |
| irq_ack | output | NREQ | Acknowledge to the winning request line |

## Verification
Each output has a fixed due cycle. The first push shows one cycle after the accepting boundary, the status push two cycles after it, and the vector redirect three cycles after it. The status pop shows one cycle after a return boundary, the address pop and its redirect or chaining decision two cycles after it, and a chained push three cycles after it. Restored enable bits read back in the address-pop cycle, and stack-pointer updates show one cycle after each transfer. The bench drives every input on the falling edge and checks outputs on the falling edge of exactly the cycle in which each is due, tracking its own copy of the stack pointer. Masked cases are checked as the absence of a write in the cycle where a push would otherwise appear.

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int NREQ = 4,
  parameter int AW = 16,
  parameter int GIE_BIT = 3,
  parameter int CPUOFF_BIT = 4,
  parameter logic [AW-1:0] SP_INIT = 16'h0100,
  parameter logic [AW-1:0] VEC_BASE = 16'hFFE0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            insn_done,
  input  logic            op_reti,
  input  logic            op_eint,
  input  logic            op_dint,
  input  logic            op_sleep,
  input  logic [AW-1:0]   next_pc,
  input  logic [AW-1:0]   sr_in,
  input  logic [AW-1:0]   stk_rdata,
  output logic            stk_we,
  output logic            stk_re,
  output logic [AW-1:0]   stk_addr,
  output logic [AW-1:0]   stk_wdata,
  output logic            sr_load,
  output logic [AW-1:0]   sp,
  output logic            gie,
  output logic            cpuoff,
  output logic            busy,
  output logic            redirect,
  output logic            redirect_vec,
  output logic [AW-1:0]   redirect_addr,
  output logic [NREQ-1:0] irq_ack
);

  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam logic [AW-1:0] WSTEP = AW'(2);

  typedef enum logic [2:0] {S_RUN, S_PSH_PC, S_PSH_SR, S_VEC, S_POP_SR, S_POP_PC} st_t;

  st_t           st;
  logic [AW-1:0] sp_q, ret_pc, sr_word;
  logic          gie_q, off_q;
  logic [IW-1:0] idx_q, win;

  wire pend  = |req;
  wire plain = insn_done & ~(op_reti | op_eint | op_dint | op_sleep);
  wire take  = gie_q & pend & (off_q | plain);
  wire chain = gie_q & pend;

  always_comb begin
    win = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (req[i]) win = IW'(i);
  end

  always_comb begin
    sr_word = sr_in;
    sr_word[GIE_BIT] = gie_q;
    sr_word[CPUOFF_BIT] = off_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_RUN;
      sp_q   <= SP_INIT;
      gie_q  <= 1'b0;
      off_q  <= 1'b0;
      ret_pc <= '0;
      idx_q  <= '0;
    end else begin
      case (st)
        S_RUN: begin
          if (insn_done) ret_pc <= next_pc;
          if (take) begin
            st    <= S_PSH_PC;
            idx_q <= win;
          end else if (insn_done) begin
            if (op_reti)  st <= S_POP_SR;
            if (op_eint)  gie_q <= 1'b1;
            if (op_dint)  gie_q <= 1'b0;
            if (op_sleep) off_q <= 1'b1;
          end
        end
        S_PSH_PC: begin
          sp_q <= sp_q - WSTEP;
          st   <= S_PSH_SR;
        end
        S_PSH_SR: begin
          sp_q  <= sp_q - WSTEP;
          gie_q <= 1'b0;
          off_q <= 1'b0;
          st    <= S_VEC;
        end
        S_VEC: st <= S_RUN;
        S_POP_SR: begin
          sp_q  <= sp_q + WSTEP;
          gie_q <= stk_rdata[GIE_BIT];
          off_q <= stk_rdata[CPUOFF_BIT];
          st    <= S_POP_PC;
        end
        S_POP_PC: begin
          sp_q   <= sp_q + WSTEP;
          ret_pc <= stk_rdata;
          if (chain) begin
            st    <= S_PSH_PC;
            idx_q <= win;
          end else begin
            st <= S_RUN;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign stk_we        = (st == S_PSH_PC) || (st == S_PSH_SR);
  assign stk_re        = (st == S_POP_SR) || (st == S_POP_PC);
  assign stk_addr      = stk_we ? sp_q - WSTEP : sp_q;
  assign stk_wdata     = (st == S_PSH_PC) ? ret_pc : sr_word;
  assign sr_load       = (st == S_POP_SR);
  assign redirect_vec  = (st == S_VEC);
  assign redirect      = redirect_vec || ((st == S_POP_PC) && !chain);
  assign redirect_addr = redirect_vec ? VEC_BASE + (AW'(idx_q) << 1) : stk_rdata;
  assign irq_ack       = redirect_vec ? (NREQ'(1) << idx_q) : '0;
  assign busy          = (st != S_RUN);
  assign sp            = sp_q;
  assign gie           = gie_q;
  assign cpuoff        = off_q;

  assert_push_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |=> sp == $past(sp) - WSTEP);

  assert_pop_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_re |=> sp == $past(sp) + WSTEP);

  assert_pc_after_sr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |=> (stk_re && !sr_load));

  assert_vec_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vec |-> (!gie && !cpuoff));

  assert_eint_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cpuoff && insn_done && op_eint) |=> !stk_we);

  assert_chain_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_re && !sr_load && gie && pend) |=> (stk_we && !redirect));

endmodule

// File: tb/irq_sequencer_test.sv
`timescale 1ns/1ps
module irq_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic        insn_done = 1'b0, op_reti = 1'b0, op_eint = 1'b0, op_dint = 1'b0, op_sleep = 1'b0;
  logic [15:0] next_pc = '0;
  logic [15:0] sr_in = 16'h0001;
  logic [15:0] stk_rdata;
  logic        stk_we, stk_re, sr_load, gie, cpuoff, busy, redirect, redirect_vec;
  logic [15:0] stk_addr, stk_wdata, sp, redirect_addr;
  logic [3:0]  irq_ack;

  logic [15:0] mem [128];
  logic [15:0] esp = 16'h0100;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req(req), .insn_done(insn_done),
    .op_reti(op_reti), .op_eint(op_eint), .op_dint(op_dint), .op_sleep(op_sleep),
    .next_pc(next_pc), .sr_in(sr_in), .stk_rdata(stk_rdata),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .sr_load(sr_load), .sp(sp), .gie(gie), .cpuoff(cpuoff), .busy(busy),
    .redirect(redirect), .redirect_vec(redirect_vec), .redirect_addr(redirect_addr),
    .irq_ack(irq_ack)
  );

  assign stk_rdata = mem[stk_addr[7:1]];
  always @(posedge clk) if (stk_we) mem[stk_addr[7:1]] <= stk_wdata;

  localparam logic [7:0] PRIO_TBL [6] = '{
    {4'b0001, 4'd0}, {4'b0110, 4'd1}, {4'b1100, 4'd2},
    {4'b1000, 4'd3}, {4'b1111, 4'd0}, {4'b1010, 4'd1}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic boundary(input logic [15:0] pc, input bit r, input bit e, input bit d, input bit s);
    next_pc = pc; insn_done = 1'b1;
    op_reti = r; op_eint = e; op_dint = d; op_sleep = s;
    @(negedge clk);
    insn_done = 1'b0; op_reti = 1'b0; op_eint = 1'b0; op_dint = 1'b0; op_sleep = 1'b0;
  endtask

  task automatic expect_entry(input logic [15:0] pc, input logic [15:0] srw, input int idx);
    chk("R2 pc push we", 16'(stk_we), 16'd1);
    chk("R2 pc push addr", stk_addr, esp - 16'd2);
    chk("R2 pc push data", stk_wdata, pc);
    @(negedge clk);
    chk("R2 sr push we", 16'(stk_we), 16'd1);
    chk("R2 sr push addr", stk_addr, esp - 16'd4);
    chk("R2 sr push data", stk_wdata, srw);
    chk("R10 sp after one push", sp, esp - 16'd2);
    @(negedge clk);
    esp = esp - 16'd4;
    chk("R2 vector redirect", 16'({redirect, redirect_vec}), 16'd3);
    chk("R3 vector address", redirect_addr, 16'hFFE0 + 16'(idx * 2));
    chk("R3 ack line", 16'(irq_ack), 16'(4'b0001 << idx));
    chk("R2 enables cleared", 16'({gie, cpuoff}), 16'd0);
    chk("R10 sp after two pushes", sp, esp);
    req[idx] = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_return(input logic [15:0] pc, input bit g, input bit off, input bit chain);
    chk("R4 sr pop first", 16'({stk_re, sr_load}), 16'd3);
    chk("R4 sr pop addr", stk_addr, esp);
    @(negedge clk);
    esp = esp + 16'd2;
    chk("R4 pc pop", 16'({stk_re, sr_load}), 16'd2);
    chk("R4 pc pop addr", stk_addr, esp);
    chk("R5 restored gie", 16'(gie), 16'(g));
    chk("R5 restored cpuoff", 16'(cpuoff), 16'(off));
    if (chain) begin
      chk("R6 no program redirect", 16'(redirect), 16'd0);
    end else begin
      chk("R4 return redirect", 16'({redirect, redirect_vec}), 16'd2);
      chk("R4 return address", redirect_addr, pc);
    end
    @(negedge clk);
    esp = esp + 16'd2;
    chk("R10 sp after pops", sp, esp);
    chk("R6 busy after pop", 16'(busy), 16'(chain));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset sp", sp, 16'h0100);
    chk("R11 reset flags", 16'({gie, cpuoff, busy, stk_we, stk_re}), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    req = 4'b0001;
    boundary(16'h1000, 0, 0, 0, 0);
    chk("R8 masked after reset", 16'({stk_we, busy}), 16'd0);

    boundary(16'h1002, 0, 1, 0, 0);
    chk("R7 no accept at enable", 16'(stk_we), 16'd0);
    chk("R7 enable set", 16'(gie), 16'd1);
    @(negedge clk);
    chk("R1 no accept mid-instruction", 16'(stk_we), 16'd0);
    @(negedge clk);
    chk("R1 no accept mid-instruction", 16'(busy), 16'd0);
    boundary(16'h1004, 0, 0, 0, 0);
    expect_entry(16'h1004, 16'h0009, 0);
    boundary(16'h0000, 1, 0, 0, 0);
    expect_return(16'h1004, 1, 0, 0);

    for (int i = 0; i < 6; i++) begin
      req = PRIO_TBL[i][7:4];
      boundary(16'h2000 + 16'(i * 4), 0, 0, 0, 0);
      expect_entry(16'h2000 + 16'(i * 4), 16'h0009, int'(PRIO_TBL[i][3:0]));
      req = '0;
      boundary(16'h0000, 1, 0, 0, 0);
      expect_return(16'h2000 + 16'(i * 4), 1, 0, 0);
    end

    req = 4'b0001;
    boundary(16'h3000, 0, 0, 0, 0);
    expect_entry(16'h3000, 16'h0009, 0);
    req = 4'b0100;
    boundary(16'h0000, 1, 0, 0, 0);
    expect_return(16'h3000, 1, 0, 1);
    expect_entry(16'h3000, 16'h0009, 2);
    req = '0;
    boundary(16'h0000, 1, 0, 0, 0);
    expect_return(16'h3000, 1, 0, 0);

    boundary(16'h4000, 0, 0, 0, 1);
    chk("R9 sleep sets cpuoff", 16'(cpuoff), 16'd1);
    chk("R9 no transfer asleep", 16'(stk_we), 16'd0);
    @(negedge clk);
    chk("R9 still asleep", 16'({cpuoff, busy}), 16'd2);
    req = 4'b0010;
    @(negedge clk);
    expect_entry(16'h4000, 16'h0019, 1);
    boundary(16'h0000, 1, 0, 0, 0);
    expect_return(16'h4000, 1, 1, 0);
    chk("R5 back to sleep", 16'(cpuoff), 16'd1);

    req = 4'b0001;
    @(negedge clk);
    expect_entry(16'h4000, 16'h0019, 0);
    mem[esp[7:1]] = 16'h0009;
    boundary(16'h0000, 1, 0, 0, 0);
    expect_return(16'h4000, 1, 0, 0);
    chk("R5 awake after return", 16'(cpuoff), 16'd0);

    req = 4'b0001;
    boundary(16'h5000, 0, 0, 1, 0);
    chk("R8 no accept at disable", 16'(stk_we), 16'd0);
    chk("R8 enable cleared", 16'(gie), 16'd0);
    boundary(16'h5002, 0, 0, 0, 0);
    chk("R8 no accept after disable", 16'({stk_we, busy}), 16'd0);
    chk("R11 sp home", sp, 16'h0100);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule